// File: doc/BRIEF.md
# Slot Hot-Plug Register Block

This block holds the slot capability, slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches them through a dword-wide configuration port with byte enables. Hardware reports slot events on single-cycle inputs: a hot insertion, a device found present at boot, and an attention button press. The block turns the combined, enabled event state into one notification. The notification goes out as an MSI-X request pulse, an MSI request pulse or a legacy INTx level, selected by two enable inputs. A software command that turns slot power off while a device is present produces a one-cycle removal request.

The register set uses the standard slot register bit layout. Dword `CS_IDX` holds control in bits 15:0 and status in bits 31:16. Dword `CAP_IDX` holds the read-only capability word. Every command completes at once, so any write that touches control also sets the command-completed event.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While reset is high, the block loads its reset values, and they read back after reset.
  - Control: attention indicator (bits 7:6) = 11 (off); all enable bits and the interlock bit are 0.
  - Control with a power controller present: if `slot_populated` is set, power control (bit 10) = 0 and power indicator (bits 9:8) = 01 (on). Otherwise power control = 1 and power indicator = 11 (off).
  - Control without a power controller: power indicator = 11 and power control = 0.
  - Status: presence state (bit 6) takes `slot_populated`; every other status bit is 0.
  - Capability reads `SLOT_NUM<<19 | 1<<17 | 0x79 | (power controller ? 2 : 0)`.
- R2: Control writes obey byte enables.
  - Writable bits: button enable (0), presence-change enable (3), command-complete enable (4), hot-plug interrupt enable (5), attention indicator (7:6) and power indicator (9:8).
  - Power control (10) is writable only when a power controller exists.
  - All other control bits read 0 or hold.
  - Read data appears on `cfg_rdata` at the clock edge that samples `cfg_rd`.
- R3: Status event bits are write-one-to-clear: button pressed (0), presence changed (3) and command completed (4). Writes to other status bits have no effect.
- R4: Notification level and when a message is sent.
  - The level is true when hot-plug interrupt enable is set and at least one of bits 0, 3 and 4 is set both in status and in control.
  - A notification is sent only when the level changes, in either direction, on a cycle with a hardware event or a control write.
  - An event whose status bit is already set sends nothing.
- R5: Delivery priority is MSI-X, then MSI, then INTx. A message request is a one-cycle pulse, and at most one kind is raised at a time.
- R6: With neither MSI-X nor MSI enabled, INTx follows the level at each notification. A status-only write recomputes the level quietly: it sends no message, and it drops INTx if the level is now false.
- R7: Writing 1 to the interlock control bit (11) toggles the interlock status bit (7). The control bit always reads 0.
- R8: Removal command.
  - Trigger: presence state is set, and a control write to byte 1 carries power control = 1 and power indicator = 11.
  - Result: `remove_req` pulses for one cycle, presence state clears and presence changed is set.
- R9: Every write with either control byte enabled sets command completed.
- R10: A hot insertion sets presence state, presence changed and button pressed together. A boot-time presence report sets only presence state and sends no notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | AW | Dword index |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| slot_populated | input | 1 | Slot occupancy, sampled during reset |
| ev_insert | input | 1 | Hot insertion event pulse |
| ev_boot | input | 1 | Boot-time presence pulse |
| ev_button | input | 1 | Attention button pulse |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| msix_req | output | 1 | MSI-X message request pulse |
| msi_req | output | 1 | MSI message request pulse |
| intx | output | 1 | Legacy interrupt level |
| remove_req | output | 1 | Device removal request pulse |

## Verification
The following results become valid at the same rising edge that samples the stimulus (a write, a read or an event pulse):
- every register update;
- the message pulses;
- the INTx level;
- the removal pulse;
- read data.

Each bench task drives its inputs on the falling edge, waits for the next rising edge, and samples one nanosecond later. Pulses are checked in that cycle and again one cycle later, to confirm they have dropped. Register contents are confirmed by a read issued after the stimulus, whose data is sampled the same way.

// File: rtl/hp_slot_pkg.sv
`timescale 1ns/1ps
package hp_slot_pkg;
  // control bit positions (standard slot control layout)
  localparam int CTL_ABPE = 0;
  localparam int CTL_PDCE = 3;
  localparam int CTL_CCIE = 4;
  localparam int CTL_HPIE = 5;
  localparam int CTL_AIC  = 6;
  localparam int CTL_PIC  = 8;
  localparam int CTL_PCC  = 10;
  localparam int CTL_EIC  = 11;
  // status bit positions; event bits share positions with their enables
  localparam int STS_ABP  = 0;
  localparam int STS_PDC  = 3;
  localparam int STS_CC   = 4;
  localparam int STS_PDS  = 6;
  localparam int STS_EIS  = 7;
  localparam logic [15:0] EVT_MASK = (16'h1 << STS_ABP) | (16'h1 << STS_PDC) | (16'h1 << STS_CC);

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_t;

  typedef struct packed {
    logic insert;
    logic boot;
    logic button;
  } hp_evt_t;
endpackage

// File: rtl/hp_ctl_reg.sv
`timescale 1ns/1ps
module hp_ctl_reg
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        slot_populated,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [15:0] wdata,
  input  logic        pds_now,
  output logic [15:0] ctl_q,
  output logic [15:0] ctl_nxt,
  output logic        eic_hit,
  output logic        remove_hit
);
  localparam logic [15:0] PWR_BIT = 16'h1 << CTL_PCC;
  localparam logic [15:0] WMASK   = 16'h03F9 | (HAS_PWR_CTL ? PWR_BIT : 16'h0000);

  logic [15:0] rst_val;

  always_comb begin
    rst_val = '0;
    rst_val[CTL_AIC +: 2] = IND_OFF;
    if (HAS_PWR_CTL && slot_populated) begin
      rst_val[CTL_PIC +: 2] = IND_ON;
    end else begin
      rst_val[CTL_PIC +: 2] = IND_OFF;
      rst_val[CTL_PCC]      = HAS_PWR_CTL;
    end
  end

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_lo) ctl_nxt[7:0]  = (ctl_q[7:0]  & ~WMASK[7:0])  | (wdata[7:0]  & WMASK[7:0]);
    if (wr_hi) ctl_nxt[15:8] = (ctl_q[15:8] & ~WMASK[15:8]) | (wdata[15:8] & WMASK[15:8]);
  end

  assign eic_hit    = wr_hi && wdata[CTL_EIC];
  assign remove_hit = wr_hi && pds_now && wdata[CTL_PCC] &&
                      (wdata[CTL_PIC +: 2] == IND_OFF);

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= rst_val;
    else     ctl_q <= ctl_nxt;
  end

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo && !wr_hi) |=> $stable(ctl_q));
endmodule

// File: rtl/hp_sts_reg.sv
`timescale 1ns/1ps
module hp_sts_reg
  import hp_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        slot_populated,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [15:0] wdata,
  input  hp_evt_t     evt,
  input  logic        ctl_write,
  input  logic        eic_hit,
  input  logic        remove_hit,
  output logic [15:0] sts_q,
  output logic [15:0] sts_nxt,
  output logic        notify_trig
);
  always_comb begin
    sts_nxt = sts_q;
    if (wr_lo) sts_nxt[7:0]  = sts_nxt[7:0]  & ~(wdata[7:0]  & EVT_MASK[7:0]);
    if (wr_hi) sts_nxt[15:8] = sts_nxt[15:8] & ~(wdata[15:8] & EVT_MASK[15:8]);
    if (eic_hit) sts_nxt[STS_EIS] = ~sts_q[STS_EIS];
    if (remove_hit) begin
      sts_nxt[STS_PDS] = 1'b0;
      sts_nxt[STS_PDC] = 1'b1;
    end
    if (evt.boot) sts_nxt[STS_PDS] = 1'b1;
    if (evt.insert) begin
      sts_nxt[STS_PDS] = 1'b1;
      sts_nxt[STS_PDC] = 1'b1;
      sts_nxt[STS_ABP] = 1'b1;
    end
    if (evt.button) sts_nxt[STS_ABP] = 1'b1;
    if (ctl_write)  sts_nxt[STS_CC]  = 1'b1;
  end

  assign notify_trig = evt.insert | evt.button | remove_hit | ctl_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      sts_q[STS_PDS] <= slot_populated;
    end else begin
      sts_q <= sts_nxt;
    end
  end

  // R9
  cc_set_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_write |=> sts_q[STS_CC]);
  // R7
  eis_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    eic_hit |=> (sts_q[STS_EIS] != $past(sts_q[STS_EIS])));
  // R8
  remove_sts_chk: assert property (@(posedge clk) disable iff (rst)
    (remove_hit && !evt.insert && !evt.boot) |=> (!sts_q[STS_PDS] && sts_q[STS_PDC]));
  // R10
  insert_sts_chk: assert property (@(posedge clk) disable iff (rst)
    evt.insert |=> (sts_q[STS_PDS] && sts_q[STS_PDC] && sts_q[STS_ABP]));
endmodule

// File: rtl/hp_irq.sv
`timescale 1ns/1ps
module hp_irq (
  input  logic clk,
  input  logic rst,
  input  logic level_nxt,
  input  logic notify_trig,
  input  logic sts_wr,
  input  logic msix_en,
  input  logic msi_en,
  output logic msix_req,
  output logic msi_req,
  output logic intx
);
  logic level_q;
  logic send;
  logic legacy;

  assign send   = (level_nxt != level_q) && notify_trig;
  assign legacy = !msix_en && !msi_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= 1'b0;
      msix_req <= 1'b0;
      msi_req  <= 1'b0;
      intx     <= 1'b0;
    end else begin
      level_q  <= level_nxt;
      msix_req <= send && msix_en;
      msi_req  <= send && !msix_en && msi_en;
      if (send && legacy)                      intx <= level_nxt;
      else if (sts_wr && legacy && !level_nxt) intx <= 1'b0;
    end
  end

  // R5
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    !(msix_req && msi_req));
  // R4
  msg_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (msix_req || msi_req) |-> (level_q != $past(level_q)));
endmodule

// File: rtl/hp_slot_ctrl.sv
`timescale 1ns/1ps
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int SLOT_NUM    = 5,
  parameter bit HAS_PWR_CTL = 1'b1,
  parameter int AW          = 2,
  parameter int CAP_IDX     = 0,
  parameter int CS_IDX      = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [AW-1:0] cfg_addr,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          slot_populated,
  input  logic          ev_insert,
  input  logic          ev_boot,
  input  logic          ev_button,
  input  logic          msix_en,
  input  logic          msi_en,
  output logic          msix_req,
  output logic          msi_req,
  output logic          intx,
  output logic          remove_req
);
  localparam logic [31:0] CAP_VAL = (32'(SLOT_NUM) << 19) | (32'h1 << 17) | 32'h79 |
                                    (HAS_PWR_CTL ? 32'h2 : 32'h0);

  logic        cs_wr;
  logic        ctl_wr_lo, ctl_wr_hi, sts_wr_lo, sts_wr_hi;
  logic [15:0] ctl_q, ctl_nxt, sts_q, sts_nxt;
  logic        eic_hit, remove_hit, notify_trig, level_nxt;
  hp_evt_t     evt;

  assign cs_wr     = cfg_wr && (cfg_addr == AW'(CS_IDX));
  assign ctl_wr_lo = cs_wr && cfg_be[0];
  assign ctl_wr_hi = cs_wr && cfg_be[1];
  assign sts_wr_lo = cs_wr && cfg_be[2];
  assign sts_wr_hi = cs_wr && cfg_be[3];
  assign evt       = '{insert: ev_insert, boot: ev_boot, button: ev_button};

  hp_ctl_reg #(.HAS_PWR_CTL(HAS_PWR_CTL)) u_ctl (
    .clk(clk), .rst(rst), .slot_populated(slot_populated),
    .wr_lo(ctl_wr_lo), .wr_hi(ctl_wr_hi), .wdata(cfg_wdata[15:0]),
    .pds_now(sts_q[STS_PDS]), .ctl_q(ctl_q), .ctl_nxt(ctl_nxt),
    .eic_hit(eic_hit), .remove_hit(remove_hit)
  );

  hp_sts_reg u_sts (
    .clk(clk), .rst(rst), .slot_populated(slot_populated),
    .wr_lo(sts_wr_lo), .wr_hi(sts_wr_hi), .wdata(cfg_wdata[31:16]),
    .evt(evt), .ctl_write(ctl_wr_lo || ctl_wr_hi),
    .eic_hit(eic_hit), .remove_hit(remove_hit),
    .sts_q(sts_q), .sts_nxt(sts_nxt), .notify_trig(notify_trig)
  );

  assign level_nxt = ctl_nxt[CTL_HPIE] && (|(ctl_nxt & sts_nxt & EVT_MASK));

  hp_irq u_irq (
    .clk(clk), .rst(rst), .level_nxt(level_nxt), .notify_trig(notify_trig),
    .sts_wr(sts_wr_lo || sts_wr_hi), .msix_en(msix_en), .msi_en(msi_en),
    .msix_req(msix_req), .msi_req(msi_req), .intx(intx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      remove_req <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      remove_req <= remove_hit;
      if (cfg_rd) begin
        if (cfg_addr == AW'(CAP_IDX))     cfg_rdata <= CAP_VAL;
        else if (cfg_addr == AW'(CS_IDX)) cfg_rdata <= {sts_q, ctl_q};
        else                              cfg_rdata <= '0;
      end
    end
  end

  // R8
  remove_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    remove_req |=> !remove_req);
endmodule

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        slot_populated = 1'b1;
  logic        ev_insert = 1'b0, ev_boot = 1'b0, ev_button = 1'b0;
  logic        msix_en = 1'b0, msi_en = 1'b0;
  logic        msix_req, msi_req, intx, remove_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  hp_slot_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .slot_populated(slot_populated), .ev_insert(ev_insert), .ev_boot(ev_boot),
    .ev_button(ev_button), .msix_en(msix_en), .msi_en(msi_en),
    .msix_req(msix_req), .msi_req(msi_req), .intx(intx), .remove_req(remove_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pop);
    @(negedge clk);
    rst = 1'b1; slot_populated = pop; msix_en = 1'b0; msi_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(posedge clk); #1;
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic evt(input bit ins, input bit boot, input bit btn);
    @(negedge clk);
    ev_insert = ins; ev_boot = boot; ev_button = btn;
    @(posedge clk); #1;
    ev_insert = 1'b0; ev_boot = 1'b0; ev_button = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R1 intx after reset", 32'(intx), 0);
    chk("R1 remove after reset", 32'(remove_req), 0);
    rdreg(2'd0, rd); chk("R1 capability", rd, 32'h002A007B);
    rdreg(2'd1, rd); chk("R1 ctl/sts populated", rd, 32'h004001C0);
    do_reset(1'b0);
    rdreg(2'd1, rd); chk("R1 ctl/sts empty", rd, 32'h000007C0);
  endtask

  task automatic t_mask();
    do_reset(1'b0);
    wr(4'b0011, 32'h0000FFFF);
    chk("R6 intx rises on ctl write", 32'(intx), 1);
    rdreg(2'd1, rd); chk("R2 writable mask", rd, 32'h009007F9);
    wr(4'b0001, 32'h0);
    chk("R6 intx falls on ctl write", 32'(intx), 0);
    rdreg(2'd1, rd); chk("R2 byte enable", rd, 32'h00900700);
    wr(4'b1100, 32'hFFFF0000);
    rdreg(2'd1, rd); chk("R3 w1c keeps ro bits", rd, 32'h00800700);
  endtask

  task automatic t_level();
    do_reset(1'b1);
    wr(4'b0011, 32'h000001E1);
    chk("R4 level low no event", 32'(intx), 0);
    evt(1'b0, 1'b0, 1'b1);
    chk("R4 button raises intx", 32'(intx), 1);
    evt(1'b0, 1'b0, 1'b1);
    chk("R4 repeat keeps intx", 32'(intx), 1);
    wr(4'b1100, 32'h00010000);
    chk("R6 status clear drops intx", 32'(intx), 0);
    rdreg(2'd1, rd); chk("R9 cc after ctl write", rd, 32'h005001E1);
  endtask

  task automatic t_msg();
    do_reset(1'b1);
    msi_en = 1'b1;
    wr(4'b0011, 32'h000001E1);
    chk("R4 no msg without change", 32'(msi_req), 0);
    evt(1'b0, 1'b0, 1'b1);
    chk("R5 msi pulse", 32'(msi_req), 1);
    chk("R5 no msix", 32'(msix_req), 0);
    chk("R5 intx idle under msi", 32'(intx), 0);
    @(posedge clk); #1;
    chk("R5 msi pulse width", 32'(msi_req), 0);
    evt(1'b0, 1'b0, 1'b1);
    chk("R4 repeat event no msg", 32'(msi_req), 0);
    wr(4'b1100, 32'h00010000);
    chk("R6 quiet status clear", 32'(msi_req), 0);
    evt(1'b0, 1'b0, 1'b1);
    chk("R4 msg after re-arm", 32'(msi_req), 1);
    msix_en = 1'b1;
    wr(4'b1100, 32'h00010000);
    evt(1'b0, 1'b0, 1'b1);
    chk("R5 msix wins", 32'(msix_req), 1);
    chk("R5 msi suppressed", 32'(msi_req), 0);
    wr(4'b0011, 32'h000001C0);
    chk("R4 msg on falling level", 32'(msix_req), 1);
  endtask

  task automatic t_eic();
    do_reset(1'b1);
    wr(4'b0010, 32'h00000800);
    rdreg(2'd1, rd); chk("R7 eis set, eic reads 0", rd, 32'h00D000C0);
    wr(4'b0010, 32'h00000800);
    rdreg(2'd1, rd); chk("R7 eis toggled back", rd, 32'h005000C0);
  endtask

  task automatic t_remove();
    do_reset(1'b1);
    wr(4'b0011, 32'h000007C0);
    chk("R8 remove pulse", 32'(remove_req), 1);
    @(posedge clk); #1;
    chk("R8 remove pulse width", 32'(remove_req), 0);
    rdreg(2'd1, rd); chk("R8 presence cleared", rd, 32'h001807C0);
    wr(4'b0011, 32'h000007C0);
    chk("R8 no remove when absent", 32'(remove_req), 0);
    do_reset(1'b1);
    wr(4'b0011, 32'h000006C0);
    chk("R8 blink indicator no remove", 32'(remove_req), 0);
    rdreg(2'd1, rd); chk("R8 presence kept", rd, 32'h005006C0);
  endtask

  task automatic t_insert();
    do_reset(1'b0);
    wr(4'b0011, 32'h000007E9);
    evt(1'b0, 1'b1, 1'b0);
    chk("R10 boot no notify", 32'(intx), 0);
    rdreg(2'd1, rd); chk("R10 boot sets pds only", rd, 32'h005007E9);
    do_reset(1'b0);
    wr(4'b0011, 32'h000007E9);
    evt(1'b1, 1'b0, 1'b0);
    chk("R10 insert notifies", 32'(intx), 1);
    rdreg(2'd1, rd); chk("R10 insert status", rd, 32'h005907E9);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_level();
    t_msg();
    t_eic();
    t_remove();
    t_insert();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule